// File: doc/BRIEF.md
# LED Matrix Row Scan Controller

This block refreshes a multiplexed dot-matrix LED display of 7 rows and 30 columns, built as six characters of 5x7 dots, 210 dots in all. A frame store keeps one 30-bit column pattern per row and is loaded through a one-cycle write port. The block visits the rows one at a time. For each row it reads the stored pattern, pads it to 32 bits and shifts it out on a serial clock and data pair into two cascaded 16-bit constant-current driver shift registers. It then waits, pulses a latch, waits again, and only then selects the row. The row select is a 3-bit code for an external 3-to-8 decoder with active-low outputs.

While a row's bits are shifted and latched, the row enable is low. This blanks the display, so the drivers' outputs never light the wrong row. Each row stays lit for a programmable dwell, which is about 1 ms at the default setting. The scan then moves on to the next row.

The sequencer walks through six named states, in order: FETCH, SHIFT, PRE, LATCH, POST, SHOW, and back to FETCH.

| State | Role | Moves on |
|-------|------|----------|
| FETCH | Reads the row and starts the serializer | after one cycle |
| SHIFT | Waits for the serializer | on the serializer's completion |
| PRE | Settle time before the latch | after its timer ends |
| LATCH | Latch held high | after its timer ends |
| POST | Settle time after the latch | after its timer ends |
| SHOW | Row lit for the dwell | after its timer ends, advancing the row number |

The serializer has three states: IDLE, LOW and HIGH. A start moves it from IDLE to LOW. When its timer ends it moves from LOW to HIGH. When its timer ends in HIGH, it goes back to LOW for the next bit, or to IDLE after the final bit.

Top module: `dotmatrix_scanner`

## Requirements
- R1: While rst_n is low, ser_clk, ser_data, drv_latch and row_on are 0 and row_sel is 0.
- R2: For each row, exactly 32 bits are shifted, most significant first, with ser_data stable at each ser_clk rising edge. The word is {p[29:15], 0, p[14:0], 0}, where p is that row's pattern. Each 16-bit driver therefore receives 15 columns and a 0 in its least significant bit.
- R3: During a shift, ser_clk is low for SCLK_HALF clocks and high for SCLK_HALF clocks, so its rising edges are 2*SCLK_HALF clocks apart.
- R4: After the last bit, the block waits SETTLE clocks. It then holds drv_latch high for LATCH_W clocks, with ser_clk low. It waits SETTLE more clocks before the row is selected, so row_on rises exactly SETTLE clocks after drv_latch falls.
- R5: row_on is low for the whole shift and latch of a row. No ser_clk rising edge and no drv_latch pulse occurs while row_on is high.
- R6: Rows are shown in the order 0, 1, ..., 6 and then 0 again. The first row shown after reset is 0, and row_sel is always below 7.
- R7: row_on stays high for exactly DWELL clocks per row, and row_sel does not change while row_on is high.
- R8: A write of wr_data to row wr_row with wr_en high is captured on the clock edge. It is seen the next time that row is fetched, and fetching happens in the clock after that row's slot begins. A write to the row being shown appears only on its next scan.
- R9: A write with wr_row equal to 7 changes no stored pattern.
- R10: After reset every stored pattern is 0, so the first frame shifts all-zero words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Frame store write strobe |
| wr_row | input | 3 | Row number written |
| wr_data | input | 30 | Column pattern, bit 29 is the leftmost column |
| ser_clk | output | 1 | Driver shift clock |
| ser_data | output | 1 | Driver serial data |
| drv_latch | output | 1 | Driver latch pulse |
| row_sel | output | 3 | Row code to the external decoder |
| row_on | output | 1 | Row enable; low blanks the display |

## Verification
- **Word contents.** The bench models the driver chain: it shifts in ser_data on every ser_clk rising edge and copies the chain on the drv_latch rising edge. When row_on rises, it compares the copied word with the word packed from the bench's own pattern copy.
- **Expected pattern for writes.** The bench takes a snapshot of that pattern copy when row_on falls. The fetch happens in the next clock, so this snapshot reflects every write captured up to that edge. This follows the one-cycle latency of R8.
- **Timing.** Latch width, the settle time after the latch, the dwell, and the ser_clk spacing are measured as time differences between output edges. Each is compared with a whole number of 8 ns clocks, so no check depends on sampling order at an edge.
- **Sweep.** A walking-one sweep over all 30 columns in all 7 rows covers every column position, including the two padded bits.

// File: rtl/dotmatrix_pkg.sv
package dotmatrix_pkg;

    typedef enum logic [2:0] {
        SQ_FETCH,
        SQ_SHIFT,
        SQ_PRE,
        SQ_LATCH,
        SQ_POST,
        SQ_SHOW
    } seq_state_t;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_LOW,
        SER_HIGH
    } ser_state_t;

endpackage

// File: rtl/frame_store.sv
module frame_store #(
    parameter int ROWS = 7,
    parameter int RW   = 3,
    parameter int COLS = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_row,
    input  logic [COLS-1:0] wr_data,
    input  logic [RW-1:0]   rd_row,
    output logic [COLS-1:0] rd_data
);
    logic [COLS-1:0] mem [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic hit;
        assign hit = wr_en && (wr_row == RW'(r));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[r] <= '0;
            end else if (hit) begin
                mem[r] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (rd_row == RW'(r)) begin
                rd_data = mem[r];
            end
        end
    end
endmodule

// File: rtl/column_packer.sv
module column_packer #(
    parameter int COLS = 30,
    parameter int NDRV = 2,
    parameter int DRVW = 16
) (
    input  logic [COLS-1:0]      cols,
    output logic [NDRV*DRVW-1:0] word
);
    localparam int CPD = COLS / NDRV;
    localparam int PAD = DRVW - CPD;

    for (genvar d = 0; d < NDRV; d++) begin : g_drv
        assign word[d*DRVW +: DRVW] = {cols[d*CPD +: CPD], {PAD{1'b0}}};
    end
endmodule

// File: rtl/bit_serializer.sv
module bit_serializer
    import dotmatrix_pkg::*;
#(
    parameter int W     = 32,
    parameter int SHALF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word,
    output logic         sclk,
    output logic         sdata,
    output logic         done
);
    localparam int TW = (SHALF > 1) ? $clog2(SHALF) : 1;
    localparam int IW = $clog2(W);

    ser_state_t    st;
    logic [TW-1:0] tmr;
    logic [IW-1:0] idx;
    logic [W-1:0]  sreg;
    logic          last_fall;

    assign last_fall = (st == SER_HIGH) && (tmr == '0) && (idx == IW'(W - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SER_IDLE;
            tmr  <= '0;
            idx  <= '0;
            sreg <= '0;
        end else begin
            unique case (st)
                SER_IDLE: begin
                    if (start) begin
                        sreg <= word;
                        idx  <= '0;
                        tmr  <= TW'(SHALF - 1);
                        st   <= SER_LOW;
                    end
                end
                SER_LOW: begin
                    if (tmr == '0) begin
                        tmr <= TW'(SHALF - 1);
                        st  <= SER_HIGH;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SER_HIGH: begin
                    if (tmr != '0) begin
                        tmr <= tmr - 1'b1;
                    end else if (idx == IW'(W - 1)) begin
                        st <= SER_IDLE;
                    end else begin
                        idx  <= idx + 1'b1;
                        sreg <= {sreg[W-2:0], 1'b0};
                        tmr  <= TW'(SHALF - 1);
                        st   <= SER_LOW;
                    end
                end
                default: st <= SER_IDLE;
            endcase
        end
    end

    always_comb begin
        sclk  = (st == SER_HIGH);
        sdata = sreg[W-1];
        done  = last_fall;
    end
endmodule

// File: rtl/row_sequencer.sv
module row_sequencer
    import dotmatrix_pkg::*;
#(
    parameter int ROWS   = 7,
    parameter int RW     = 3,
    parameter int SETTLE = 4,
    parameter int LATCHW = 4,
    parameter int DWELL  = 125000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_done,
    output logic          ser_start,
    output logic [RW-1:0] fetch_row,
    output logic          latch,
    output logic          row_on,
    output logic [RW-1:0] row_sel
);
    localparam int TMAX = (DWELL > SETTLE) ? ((DWELL > LATCHW) ? DWELL : LATCHW)
                                           : ((SETTLE > LATCHW) ? SETTLE : LATCHW);
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t    st;
    logic [TW-1:0] tmr;
    logic [RW-1:0] cur;
    logic [RW-1:0] shown;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= SQ_FETCH;
            tmr   <= '0;
            cur   <= '0;
            shown <= '0;
        end else begin
            unique case (st)
                SQ_FETCH: st <= SQ_SHIFT;
                SQ_SHIFT: begin
                    if (ser_done) begin
                        tmr <= TW'(SETTLE - 1);
                        st  <= SQ_PRE;
                    end
                end
                SQ_PRE: begin
                    if (tmr == '0) begin
                        tmr <= TW'(LATCHW - 1);
                        st  <= SQ_LATCH;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SQ_LATCH: begin
                    if (tmr == '0) begin
                        tmr <= TW'(SETTLE - 1);
                        st  <= SQ_POST;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SQ_POST: begin
                    if (tmr == '0) begin
                        tmr   <= TW'(DWELL - 1);
                        shown <= cur;
                        st    <= SQ_SHOW;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                SQ_SHOW: begin
                    if (tmr == '0) begin
                        cur <= (cur == RW'(ROWS - 1)) ? '0 : cur + 1'b1;
                        st  <= SQ_FETCH;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: st <= SQ_FETCH;
            endcase
        end
    end

    always_comb begin
        ser_start = (st == SQ_FETCH);
        latch     = (st == SQ_LATCH);
        row_on    = (st == SQ_SHOW);
        fetch_row = cur;
        row_sel   = shown;
    end
endmodule

// File: rtl/dotmatrix_scanner.sv
module dotmatrix_scanner #(
    parameter int ROWS       = 7,
    parameter int RW         = 3,
    parameter int COLS       = 30,
    parameter int NDRV       = 2,
    parameter int DRVW       = 16,
    parameter int SCLK_HALF  = 2,
    parameter int SETTLE     = 4,
    parameter int LATCH_W    = 4,
    parameter int DWELL      = 125000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_row,
    input  logic [COLS-1:0] wr_data,
    output logic            ser_clk,
    output logic            ser_data,
    output logic            drv_latch,
    output logic [RW-1:0]   row_sel,
    output logic            row_on
);
    localparam int CHAIN = NDRV * DRVW;

    logic [RW-1:0]    fetch_row;
    logic [COLS-1:0]  row_pat;
    logic [CHAIN-1:0] row_word;
    logic             ser_start;
    logic             ser_done;

    frame_store #(.ROWS(ROWS), .RW(RW), .COLS(COLS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_row  (fetch_row),
        .rd_data (row_pat)
    );

    column_packer #(.COLS(COLS), .NDRV(NDRV), .DRVW(DRVW)) u_pack (
        .cols (row_pat),
        .word (row_word)
    );

    bit_serializer #(.W(CHAIN), .SHALF(SCLK_HALF)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ser_start),
        .word  (row_word),
        .sclk  (ser_clk),
        .sdata (ser_data),
        .done  (ser_done)
    );

    row_sequencer #(
        .ROWS(ROWS), .RW(RW), .SETTLE(SETTLE), .LATCHW(LATCH_W), .DWELL(DWELL)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_done  (ser_done),
        .ser_start (ser_start),
        .fetch_row (fetch_row),
        .latch     (drv_latch),
        .row_on    (row_on),
        .row_sel   (row_sel)
    );
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
    parameter int ROWS = 7,
    parameter int RW   = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_clk,
    input logic          drv_latch,
    input logic          row_on,
    input logic [RW-1:0] row_sel
);
    logic          seen;
    logic [RW-1:0] last_row;
    logic [RW-1:0] nxt_row;

    assign nxt_row = seen ? ((last_row == RW'(ROWS - 1)) ? '0 : last_row + 1'b1) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            last_row <= '0;
        end else if (row_on) begin
            seen     <= 1'b1;
            last_row <= row_sel;
        end
    end

    AST_SHIFT_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> !row_on); // R5
    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        drv_latch |-> (!row_on && !ser_clk)); // R4
    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_sel < RW'(ROWS)); // R6
    AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_on) |-> (row_sel == nxt_row)); // R6
    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (row_on && $past(row_on)) |-> $stable(row_sel)); // R7
endmodule

bind dotmatrix_scanner scan_checker #(.ROWS(ROWS), .RW(RW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_clk   (ser_clk),
    .drv_latch (drv_latch),
    .row_on    (row_on),
    .row_sel   (row_sel)
);

// File: tb/tb_dotmatrix_scanner.sv
`timescale 1ns/1ps
module tb_dotmatrix_scanner;
    localparam int P_HALF = 2;
    localparam int P_SET  = 3;
    localparam int P_LAT  = 2;
    localparam int P_DW   = 40;
    localparam int TCK    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_row = '0;
    logic [29:0] wr_data = '0;
    logic        ser_clk, ser_data, drv_latch, row_on;
    logic [2:0]  row_sel;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(TCK/2) clk = ~clk;

    dotmatrix_scanner #(
        .SCLK_HALF(P_HALF), .SETTLE(P_SET), .LATCH_W(P_LAT), .DWELL(P_DW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .ser_clk(ser_clk), .ser_data(ser_data), .drv_latch(drv_latch),
        .row_sel(row_sel), .row_on(row_on)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] pack(input logic [29:0] p);
        return {p[29:15], 1'b0, p[14:0], 1'b0};
    endfunction

    logic [29:0] model [7];
    logic [29:0] snap;
    int          exp_row;
    logic [31:0] chain, latched;
    int          nbits;
    time         t_rise, t_lat_r, t_lat_f, t_on;
    bit          live, seen_lat, seen_on;

    initial begin
        for (int i = 0; i < 7; i++) model[i] = '0;
        snap = '0; exp_row = 0; chain = '0; latched = '0; nbits = 0;
        live = 0; seen_lat = 0; seen_on = 0;
        t_rise = 0; t_lat_r = 0; t_lat_f = 0; t_on = 0;
    end

    always @(posedge ser_clk) if (live) begin
        chain = {chain[30:0], ser_data};
        chk(row_on == 1'b0, "R5 blank during shift", {31'b0, row_on}, 32'd0);
        if (nbits > 0)
            chk((($time - t_rise) == 2*P_HALF*TCK), "R3 shift clock spacing",
                32'($time - t_rise), 32'(2*P_HALF*TCK));
        t_rise = $time;
        nbits++;
    end

    always @(posedge drv_latch) if (live) begin
        latched = chain;
        seen_lat = 1'b1;
        t_lat_r = $time;
        chk(nbits == 32, "R2 bits per row", 32'(nbits), 32'd32);
        chk(row_on == 1'b0, "R5 blank during latch", {31'b0, row_on}, 32'd0);
        nbits = 0;
    end

    always @(negedge drv_latch) if (live && seen_lat) begin
        t_lat_f = $time;
        chk((t_lat_f - t_lat_r) == P_LAT*TCK, "R4 latch width",
            32'(t_lat_f - t_lat_r), 32'(P_LAT*TCK));
    end

    always @(posedge row_on) if (live) begin
        seen_on = 1'b1;
        t_on = $time;
        chk(row_sel == 3'(exp_row), "R6 row order", 32'(row_sel), 32'(exp_row));
        chk(latched == pack(snap), "R2 R8 R9 R10 latched word", latched, pack(snap));
        chk((t_on - t_lat_f) == P_SET*TCK, "R4 settle after latch",
            32'(t_on - t_lat_f), 32'(P_SET*TCK));
    end

    always @(negedge row_on) if (live && seen_on) begin
        chk(($time - t_on) == P_DW*TCK, "R7 dwell", 32'($time - t_on), 32'(P_DW*TCK));
        exp_row = (exp_row == 6) ? 0 : exp_row + 1;
        snap = model[exp_row];
    end

    task automatic wr(input logic [2:0] r, input logic [29:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = r; wr_data = d;
        if (r < 3'd7) model[r] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_shows(input int n);
        for (int i = 0; i < n; i++) @(posedge row_on);
    endtask

    initial begin
        #(TCK*190000);
        bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk({ser_clk, ser_data, drv_latch, row_on, row_sel} == 7'd0, "R1 reset outputs",
            {25'b0, ser_clk, ser_data, drv_latch, row_on, row_sel}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        chk({ser_clk, drv_latch, row_on, row_sel} == 6'd0, "R1 outputs after reset",
            {26'b0, ser_clk, drv_latch, row_on, row_sel}, 32'd0);
        wait_shows(14);  // R10: two all-zero frames
        for (int k = 0; k < 30; k++) begin
            wait (row_on);
            for (int r = 0; r < 7; r++)
                wr(3'(r), 30'(1) << ((k + r) % 30));
            wait_shows(8);
        end
        wait (row_on);
        for (int r = 0; r < 7; r++) wr(3'(r), 30'h3FFF_FFFF);  // R2 padding
        wait_shows(8);
        wait (row_on);
        wr(3'd7, 30'h0000_0000);  // R9 ignored address
        wait_shows(8);
        @(negedge clk);
        wait (row_on && row_sel == 3'd3);
        wr(3'd3, 30'h2AAA_AAAA);  // R8 same-row write
        wait_shows(16);
        summary();
    end
endmodule